// File: doc/BRIEF.md
# Serial Front End for a Segment Display Nibble Memory

This block is the host-facing side of a segment display controller. A host reaches it over a short serial link. The link has an active-low select, a write strobe, a read strobe and one data line. The data line is carried here as a separate input, output and output-enable. The block keeps the 32-word by 4-bit display memory. It decodes a 3-bit operation prefix at the start of each selected transfer. It then runs one of several operations: sequential reads, sequential writes, read-modify-write on each location, or a stream of 9-bit configuration words. The configuration words are handed to a separate register block together with a one-cycle strobe.

All pins are asynchronous to the system clock. The select, both strobes and the data line pass together through a synchronizer. Strobe edges are detected in the clock domain. The address counter advances on its own after each complete nibble, so a host can stream a whole display image behind a single address. A second read port on the memory serves the display scanner and is independent of the serial traffic.

Top module: `segram_serial_port`

## Requirements
- R1: While the select input is high, any transfer in progress is dropped, the output-enable falls and the prefix collector is cleared. Partial bits sent before the select went high have no effect on memory. After the select falls again, a fresh prefix is needed.
- R2: Prefix codes (first bit sent first): 110 selects read, 101 selects write or read-modify-write, 100 selects configuration. Any other prefix makes the block ignore both strobes until the select goes high: nothing is written and the output-enable stays low.
- R3: A host bit (prefix, address, data or configuration) is taken from the data line as it stands at the rising edge of the write strobe. Values present only while the strobe is low are ignored.
- R4: In a read phase, each falling edge of the read strobe drives the next memory bit onto the data output and raises the output-enable. The output-enable is low at reset and during writes, and a rising write strobe lowers it.
- R5: After a read or write prefix, 6 address bits follow, most significant first. Each data nibble follows least significant bit first, on both write and read.
- R6: Each complete nibble advances the address by one, without a new address being sent. Address 31 is followed by address 0.
- R7: Under the 101 prefix, read strobes that come before the first write bit of a nibble read the current word without moving the address. The following four write bits replace that same word, and only then does the address advance.
- R8: Under the 100 prefix, every 9 write bits form one configuration word, first bit as the most significant. The word appears on the word output with a strobe that lasts one clock cycle. Further words follow with no repeated prefix, even when their bits look like a prefix.
- R9: Addresses 32 to 63 do not exist. Writes to them change no word, and reads from them return zero bits.
- R10: The scanner port returns the word at its address from the same memory. All 32 words are zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Active-low select from the host |
| wclk_i | input | 1 | Write strobe; bits are taken on its rising edge |
| rclk_i | input | 1 | Read strobe; bits are driven after its falling edge |
| sdio_i | input | 1 | Data line as seen at the pad |
| sdio_o | output | 1 | Data driven toward the host during reads |
| sdio_oe_o | output | 1 | Drive enable for the data pad |
| cfg_word_o | output | 9 | Last complete configuration word |
| cfg_stb_o | output | 1 | One-cycle strobe marking a new configuration word |
| scan_addr_i | input | 5 | Scanner read address |
| scan_nib_o | output | 4 | Scanner read data |

## Verification
A pin change is seen by the block at the third rising clock edge after it: two synchronizer flops, then the edge compare feeds the state registers. So a read bit, a memory word, the scanner data and the configuration strobe are all valid three cycles after the strobe edge that caused them. The bench holds every strobe level for six cycles and samples outputs on a falling clock edge at the end of that hold. Each result is therefore read a few cycles after it is due and before the next stimulus. The configuration strobe is watched on every falling clock edge, so a pulse longer than one cycle shows up as an unexpected extra word.

// File: rtl/segram_pkg.sv
package segram_pkg;

    typedef enum logic [2:0] {
        PH_PREFIX = 3'd0,
        PH_ADDR   = 3'd1,
        PH_READ   = 3'd2,
        PH_WRITE  = 3'd3,
        PH_CMD    = 3'd4,
        PH_SKIP   = 3'd5
    } phase_e;

    localparam int          PFX_BITS  = 3;
    localparam logic [2:0]  PFX_READ  = 3'b110;
    localparam logic [2:0]  PFX_WRITE = 3'b101;
    localparam logic [2:0]  PFX_CMD   = 3'b100;

endpackage

// File: rtl/segram_sync.sv
module segram_sync #(
    parameter int                 WIDTH   = 4,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign level_o = stg_q[STAGES-1];

endmodule

// File: rtl/segram_store.sv
module segram_store #(
    parameter int AW     = 6,
    parameter int DATA_W = 4,
    parameter int DEPTH  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic [AW-1:0]               addr_i,
    input  logic [DATA_W-1:0]           wdata_i,
    output logic [DATA_W-1:0]           rdata_o,
    input  logic [$clog2(DEPTH)-1:0]    scan_addr_i,
    output logic [DATA_W-1:0]           scan_data_o
);

    localparam int              IDX_W   = $clog2(DEPTH);
    localparam logic [AW:0]     DEPTH_L = (AW+1)'(DEPTH);

    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;
    logic                         in_range;

    assign in_range = ({1'b0, addr_i} < DEPTH_L);

    always_comb begin
        mem_d = mem_q;
        if (we_i && in_range) begin
            mem_d[addr_i[IDX_W-1:0]] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o     = in_range ? mem_q[addr_i[IDX_W-1:0]] : '0;
    assign scan_data_o = mem_q[scan_addr_i];

    // R9: an out-of-range write leaves the addressed alias word untouched
    a_r9_no_alias_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !in_range) |=> (mem_q[$past(addr_i[IDX_W-1:0])] == $past(mem_q[addr_i[IDX_W-1:0]])));

endmodule

// File: rtl/segram_frame_ctrl.sv
module segram_frame_ctrl
    import segram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int DATA_W = 4,
    parameter int CMD_W  = 9,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_hi_i,
    input  logic              wr_lvl_i,
    input  logic              rd_lvl_i,
    input  logic              din_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [AW-1:0]     addr_o,
    output logic              we_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              dout_o,
    output logic              oe_o,
    output logic [CMD_W-1:0]  cmd_word_o,
    output logic              cmd_valid_o
);

    localparam int               SH_W      = (CMD_W > AW) ? CMD_W : AW;
    localparam int               CNT_W     = $clog2(SH_W + 1);
    localparam int               NC_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [AW-1:0]    LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [NC_W-1:0]  LAST_BIT  = NC_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] PFX_LAST  = CNT_W'(PFX_BITS - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(AW - 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);

    typedef struct packed {
        phase_e              phase;
        logic                is_rd;
        logic [CNT_W-1:0]    cnt;
        logic [SH_W-1:0]     shift;
        logic [AW-1:0]       addr;
        logic [NC_W-1:0]     rcnt;
        logic [NC_W-1:0]     wcnt;
        logic [DATA_W-1:0]   nib;
        logic                dout;
        logic                oe;
        logic [CMD_W-1:0]    cmd;
        logic                cmd_vld;
        logic                wr_prev;
        logic                rd_prev;
    } ctl_s;

    ctl_s q, n;

    logic              wr_rise, rd_fall, rd_ok;
    logic [SH_W-1:0]   shifted;
    logic [DATA_W-1:0] nib_next;
    logic [AW-1:0]     addr_inc;

    assign wr_rise  = wr_lvl_i & ~q.wr_prev;
    assign rd_fall  = ~rd_lvl_i & q.rd_prev;
    assign shifted  = {q.shift[SH_W-2:0], din_i};
    assign addr_inc = (q.addr == LAST_ADDR) ? '0 : q.addr + 1'b1;
    assign rd_ok    = (q.phase == PH_READ) || ((q.phase == PH_WRITE) && (q.wcnt == '0));

    always_comb begin
        n        = q;
        n.cmd_vld = 1'b0;
        we_o     = 1'b0;
        nib_next = q.nib;
        nib_next[q.wcnt] = din_i;
        wdata_o  = nib_next;

        if (cs_hi_i) begin
            n = '0;
        end else begin
            if (wr_rise) begin
                n.oe = 1'b0;
            end

            if (rd_fall && rd_ok) begin
                n.dout = rd_data_i[q.rcnt];
                n.oe   = 1'b1;
                n.rcnt = q.rcnt + 1'b1;
                if ((q.phase == PH_READ) && (q.rcnt == LAST_BIT)) begin
                    n.addr = addr_inc;
                end
            end

            if (wr_rise) begin
                case (q.phase)
                    PH_PREFIX: begin
                        n.shift = shifted;
                        n.cnt   = q.cnt + 1'b1;
                        if (q.cnt == PFX_LAST) begin
                            n.cnt = '0;
                            case (shifted[PFX_BITS-1:0])
                                PFX_READ: begin
                                    n.phase = PH_ADDR;
                                    n.is_rd = 1'b1;
                                end
                                PFX_WRITE: begin
                                    n.phase = PH_ADDR;
                                    n.is_rd = 1'b0;
                                end
                                PFX_CMD:  n.phase = PH_CMD;
                                default:  n.phase = PH_SKIP;
                            endcase
                        end
                    end
                    PH_ADDR: begin
                        n.shift = shifted;
                        n.cnt   = q.cnt + 1'b1;
                        if (q.cnt == ADDR_LAST) begin
                            n.cnt   = '0;
                            n.addr  = shifted[AW-1:0];
                            n.rcnt  = '0;
                            n.wcnt  = '0;
                            n.phase = q.is_rd ? PH_READ : PH_WRITE;
                        end
                    end
                    PH_WRITE: begin
                        n.nib  = nib_next;
                        n.wcnt = q.wcnt + 1'b1;
                        if (q.wcnt == LAST_BIT) begin
                            we_o   = 1'b1;
                            n.addr = addr_inc;
                            n.rcnt = '0;
                        end
                    end
                    PH_CMD: begin
                        n.shift = shifted;
                        n.cnt   = q.cnt + 1'b1;
                        if (q.cnt == CMD_LAST) begin
                            n.cnt     = '0;
                            n.cmd     = shifted[CMD_W-1:0];
                            n.cmd_vld = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end

        n.wr_prev = wr_lvl_i;
        n.rd_prev = rd_lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.wr_prev <= 1'b1;
            q.rd_prev <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign addr_o      = q.addr;
    assign dout_o      = q.dout;
    assign oe_o        = q.oe;
    assign cmd_word_o  = q.cmd;
    assign cmd_valid_o = q.cmd_vld;

    // R1: deselect clears the drive enable, the strobe and the frame state
    a_r1_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi_i |=> (!oe_o && !cmd_valid_o && (q.phase == PH_PREFIX) && (q.cnt == '0)));

    // R4: a read strobe fall in a read phase turns the drive on
    a_r4_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_hi_i && rd_fall && (q.phase == PH_READ)) |=> oe_o);

    // R6: the word after the last address is address zero
    a_r6_addr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && (addr_o == LAST_ADDR)) |=> (addr_o == '0));

    // R7: a read inside a write-prefixed frame keeps the address in place
    a_r7_rmw_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_hi_i && rd_fall && (q.phase == PH_WRITE)) |=> $stable(addr_o));

    // R8: the configuration strobe lasts a single cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

endmodule

// File: rtl/segram_serial_port.sv
module segram_serial_port #(
    parameter int ADDR_W      = 6,
    parameter int WORDS       = 32,
    parameter int NIB_W       = 4,
    parameter int CFG_W       = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sel_n_i,
    input  logic                        wclk_i,
    input  logic                        rclk_i,
    input  logic                        sdio_i,
    output logic                        sdio_o,
    output logic                        sdio_oe_o,
    output logic [CFG_W-1:0]            cfg_word_o,
    output logic                        cfg_stb_o,
    input  logic [$clog2(WORDS)-1:0]    scan_addr_i,
    output logic [NIB_W-1:0]            scan_nib_o
);

    localparam int         PIN_N   = 4;
    localparam logic [3:0] PIN_RST = 4'b1110;

    logic [PIN_N-1:0]  pins_sync;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [NIB_W-1:0]  mem_wdata;
    logic [NIB_W-1:0]  mem_rdata;

    segram_sync #(
        .WIDTH   (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sel_n_i, wclk_i, rclk_i, sdio_i}),
        .level_o (pins_sync)
    );

    segram_frame_ctrl #(
        .AW     (ADDR_W),
        .DATA_W (NIB_W),
        .CMD_W  (CFG_W),
        .DEPTH  (WORDS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_hi_i     (pins_sync[3]),
        .wr_lvl_i    (pins_sync[2]),
        .rd_lvl_i    (pins_sync[1]),
        .din_i       (pins_sync[0]),
        .rd_data_i   (mem_rdata),
        .addr_o      (mem_addr),
        .we_o        (mem_we),
        .wdata_o     (mem_wdata),
        .dout_o      (sdio_o),
        .oe_o        (sdio_oe_o),
        .cmd_word_o  (cfg_word_o),
        .cmd_valid_o (cfg_stb_o)
    );

    segram_store #(
        .AW     (ADDR_W),
        .DATA_W (NIB_W),
        .DEPTH  (WORDS)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (mem_we),
        .addr_i      (mem_addr),
        .wdata_i     (mem_wdata),
        .rdata_o     (mem_rdata),
        .scan_addr_i (scan_addr_i),
        .scan_data_o (scan_nib_o)
    );

endmodule

// File: tb/tb_segram_serial_port.sv
`timescale 1ns/1ps
module tb_segram_serial_port;

    localparam int HOLD = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel_n, wclk, rclk, sdio;
    logic       sdio_o, sdio_oe;
    logic [8:0] cfg_word;
    logic       cfg_stb;
    logic [4:0] scan_addr;
    logic [3:0] scan_nib;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        int    val;
        string req;
    } item_t;

    item_t exp_rd[$];
    int    obs_rd[$];
    item_t exp_cfg[$];

    always #2 clk = ~clk;

    segram_serial_port dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_n_i     (sel_n),
        .wclk_i      (wclk),
        .rclk_i      (rclk),
        .sdio_i      (sdio),
        .sdio_o      (sdio_o),
        .sdio_oe_o   (sdio_oe),
        .cfg_word_o  (cfg_word),
        .cfg_stb_o   (cfg_stb),
        .scan_addr_i (scan_addr),
        .scan_nib_o  (scan_nib)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_on();
        sel_n = 1'b0;
        cyc(HOLD);
    endtask

    task automatic sel_off();
        wclk  = 1'b1;
        rclk  = 1'b1;
        sel_n = 1'b1;
        cyc(HOLD);
    endtask

    // wrong value while the strobe is low, right value just before it rises (R3)
    task automatic send_bit(input bit b);
        sdio = ~b;
        wclk = 1'b0;
        cyc(HOLD / 2);
        sdio = b;
        cyc(HOLD / 2);
        wclk = 1'b1;
        cyc(HOLD);
    endtask

    task automatic send_msb(input int val, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) send_bit(val[i]);
    endtask

    task automatic send_nib(input int val);
        for (int i = 0; i < 4; i++) send_bit(val[i]);
    endtask

    task automatic read_nib(input int exp, input string req);
        int v;
        v = 0;
        exp_rd.push_back('{exp, req});
        for (int i = 0; i < 4; i++) begin
            rclk = 1'b0;
            cyc(HOLD);
            v[i] = sdio_o;
            check("R4 drive enable during read", int'(sdio_oe), 1);
            rclk = 1'b1;
            cyc(HOLD);
        end
        obs_rd.push_back(v);
    endtask

    task automatic scan_check(input int a, input int exp, input string req);
        scan_addr = 5'(a);
        cyc(1);
        check(req, int'(scan_nib), exp);
    endtask

    // monitor: pops expected items as results appear
    initial begin
        forever begin
            @(negedge clk);
            if (obs_rd.size() > 0 && exp_rd.size() > 0) begin
                item_t e;
                int    o;
                e = exp_rd.pop_front();
                o = obs_rd.pop_front();
                check(e.req, o, e.val);
            end
            if (rst_n && cfg_stb) begin
                if (exp_cfg.size() == 0) begin
                    check("R8 unexpected config strobe", 1, 0);
                end else begin
                    item_t e;
                    e = exp_cfg.pop_front();
                    check(e.req, int'(cfg_word), e.val);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1-watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int zeros;
        rst_n = 1'b0; sel_n = 1'b1; wclk = 1'b1; rclk = 1'b1; sdio = 1'b0;
        scan_addr = '0;
        cyc(5);
        rst_n = 1'b1;
        cyc(4);

        // reset state: R4, R8, R10
        check("R4 drive enable low after reset", int'(sdio_oe), 0);
        check("R8 config strobe low after reset", int'(cfg_stb), 0);
        zeros = 0;
        for (int a = 0; a < 32; a++) begin
            scan_addr = 5'(a);
            cyc(1);
            if (scan_nib == 4'h0) zeros++;
        end
        check("R10 all words zero after reset", zeros, 32);

        // streamed write: R3, R5, R6
        sel_on();
        send_msb(3'b101, 3);
        send_msb(5, 6);
        send_nib(4'hA);
        check("R4 drive enable low while writing", int'(sdio_oe), 0);
        send_nib(4'h3);
        send_nib(4'hC);
        sel_off();
        scan_check(5, 4'hA, "R3 R5 first word");
        scan_check(6, 4'h3, "R6 second word");
        scan_check(7, 4'hC, "R6 third word");

        // wrap across the last address: R6
        sel_on();
        send_msb(3'b101, 3);
        send_msb(31, 6);
        send_nib(4'h9);
        send_nib(4'h6);
        sel_off();
        scan_check(31, 4'h9, "R6 last address");
        scan_check(0, 4'h6, "R6 wrap to zero");

        // streamed read: R4, R5, R6
        sel_on();
        send_msb(3'b110, 3);
        send_msb(5, 6);
        read_nib(4'hA, "R5 read first word");
        read_nib(4'h3, "R6 read next word");
        read_nib(4'hC, "R6 read third word");
        sel_off();
        check("R1 drive enable low after deselect", int'(sdio_oe), 0);

        sel_on();
        send_msb(3'b110, 3);
        send_msb(31, 6);
        read_nib(4'h9, "R6 read last address");
        read_nib(4'h6, "R6 read wraps to zero");
        sel_off();

        // abort in the middle of a read: R1
        sel_on();
        send_msb(3'b110, 3);
        send_msb(5, 6);
        rclk = 1'b0;
        cyc(HOLD);
        check("R4 drive enable on at read fall", int'(sdio_oe), 1);
        sel_n = 1'b1;
        cyc(HOLD);
        check("R1 deselect drops drive enable", int'(sdio_oe), 0);
        rclk = 1'b1;
        cyc(HOLD);

        // read-modify-write: R7
        sel_on();
        send_msb(3'b101, 3);
        send_msb(6, 6);
        read_nib(4'h3, "R7 read before replace");
        send_nib(4'h5);
        read_nib(4'hC, "R7 address advanced after replace");
        send_nib(4'hE);
        sel_off();
        scan_check(6, 4'h5, "R7 first word replaced");
        scan_check(7, 4'hE, "R7 second word replaced");
        scan_check(8, 4'h0, "R7 following word untouched");

        // missing addresses: R9
        sel_on();
        send_msb(3'b101, 3);
        send_msb(40, 6);
        send_nib(4'hF);
        sel_off();
        scan_check(8, 4'h0, "R9 no write through alias");
        sel_on();
        send_msb(3'b110, 3);
        send_msb(40, 6);
        read_nib(4'h0, "R9 read above range is zero");
        sel_off();

        // abort in the middle of a nibble, then bits without a prefix: R1
        sel_on();
        send_msb(3'b101, 3);
        send_msb(9, 6);
        send_bit(1'b1);
        send_bit(1'b1);
        sel_off();
        scan_check(9, 4'h0, "R1 partial nibble dropped");
        sel_on();
        send_nib(4'hF);
        sel_off();
        scan_check(9, 4'h0, "R1 bits without prefix ignored");
        sel_on();
        send_msb(3'b101, 3);
        send_msb(9, 6);
        send_nib(4'h7);
        sel_off();
        scan_check(9, 4'h7, "R1 fresh frame after abort");

        // unknown prefixes: R2
        sel_on();
        send_msb(3'b011, 3);
        send_msb(10, 6);
        send_nib(4'hF);
        sel_off();
        scan_check(10, 4'h0, "R2 unknown prefix writes nothing");
        sel_on();
        send_msb(3'b010, 3);
        rclk = 1'b0;
        cyc(HOLD);
        check("R2 unknown prefix never drives", int'(sdio_oe), 0);
        rclk = 1'b1;
        cyc(HOLD);
        sel_off();

        // configuration words back to back: R8
        exp_cfg.push_back('{9'h1A5, "R8 first config word"});
        exp_cfg.push_back('{9'h003, "R8 second config word"});
        sel_on();
        send_msb(3'b100, 3);
        send_msb(9'h1A5, 9);
        send_msb(9'h003, 9);
        sel_off();
        cyc(HOLD);
        check("R8 all config words seen", exp_cfg.size(), 0);
        check("R5 all reads compared", exp_rd.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule